// File: doc/BRIEF.md
# Vectored Nested Interrupt Controller

This block gathers up to 128 interrupt sources, each with its own priority, trigger type and vector, and drives a single interrupt request towards a processor. It is programmed through a small 32-bit register bus. Software first writes a source number into a select register. The mode, vector, enable, disable, clear, set and mask registers then act on that source only.

Each source is either level sensed or edge sensed, and either polarity can be chosen. Among the sources that are both pending and enabled, the controller picks the one with the highest priority. It requests service only when that priority is strictly above the level now being serviced. When the processor reads the acknowledge register, it receives the winner's vector, and that priority is pushed onto an internal nesting stack. Writes to the end-of-service register pop the stack again. If no interrupt can be delivered, the acknowledge read returns a programmable spurious vector instead, so the handler can return cleanly.

Bus reads are combinational: `bus_rdata` is valid in the same cycle as the access. Side effects (register writes, stack pushes, clearing pending state) take effect at the next rising clock edge.

Top module: `nest_intc`

## Requirements
- R1: Register word offsets are: select 0x00, mode 0x04, vector 0x08, acknowledge 0x0C, status 0x10, spurious 0x14, end-of-service 0x18, mask 0x1C, enable 0x20, disable 0x24, clear 0x28, set 0x2C, pending words 0x30/0x34/0x38/0x3C. The select register keeps `bus_wdata[6:0]` as the source number and ignores higher bits; it reads back zero-extended. Vector writes and reads (0x08) reach only the selected source.
- R2: The mode register (0x04) holds priority in bits [2:0], edge-sensing in bit 4 (1 = edge, 0 = level) and active-low/falling polarity in bit 5. Every other bit reads 0.
- R3: A write to the enable register (0x20) with bit 0 set enables the selected source. A write to the disable register (0x24) with bit 0 set disables it. A command write with bit 0 clear has no effect. The mask register (0x1C) reads 1 in bit 0 when the selected source is enabled. A disabled source never raises `irq_out`.
- R4: An edge-sensed source becomes pending on a rising edge of its input (polarity 0) or on a falling edge (polarity 1). It stays pending after the input returns.
- R5: A level-sensed source is pending for as long as its input sits at its active level, and stops being pending when the input leaves that level.
- R6: A write to the set register (0x2C) with bit 0 set makes the selected source pending. A write to the clear register (0x28) with bit 0 set clears its latched pending state.
- R7: Among sources that are pending and enabled, the one with the highest priority wins (7 is the highest). Among equal priorities, the lowest source number wins.
- R8: `irq_out` is high when a winner exists, the stack holds fewer than 8 levels, and either the stack is empty or the winner's priority is strictly greater than the priority on top of the stack.
- R9: When `irq_out` is high, reading the acknowledge register (0x0C) returns the winner's vector, pushes its priority and number onto the stack, and clears its pending state if it is edge sensed. A level-sensed source stays pending. While that level is active, the status register (0x10) reads 0x100 plus the source number.
- R10: When `irq_out` is low, reading the acknowledge register returns the spurious register (0x14) value and pushes a copy of the current level (priority 0 when the stack is empty). The status register then reads 0.
- R11: Each end-of-service write (0x18) pops one stack level, and the status register reverts to the interrupted level. Eight such writes always empty the stack. A write on an empty stack has no effect.
- R12: After reset all sources are disabled, with priority 0, level-high sensing and vector 0. Select, spurious and status read 0, and `irq_out` is low.
- R13: The pending words at 0x30, 0x34, 0x38 and 0x3C show the pending state of sources 0–31, 32–63, 64–95 and 96–127, one bit per source (bit n = source 32k+n), whether or not the source is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits [7:2] select the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| src_in | input | NUM_SRC | Interrupt source inputs, synchronous to `clk` |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench targets the strict priority comparison against the stack top. A design that used greater-or-equal would re-interrupt a handler with a peer of equal priority, and the bench would see `irq_out` rise while the equal-priority edge source is pending. It checks tie-breaking between a level and an edge source of equal priority: reversed ordering would return the higher-numbered vector. It checks that acknowledge clears only edge-pending state; a design that cleared level pending too would show the level bit missing from the pending word. It fills the stack with spurious acknowledges and then confirms that a pending source is held off until eight end-of-service writes drain it. A counter that wrapped or failed to saturate would either raise the request early or never raise it.

// File: rtl/nest_intc_pkg.sv
package nest_intc_pkg;

   // Source numbers are carried in a fixed-width field on the bus.
   localparam int IDX_W         = 7;
   localparam int MAX_SRC       = 1 << IDX_W;
   localparam int MODE_EDGE_BIT = 4;
   localparam int MODE_POL_BIT  = 5;
   localparam int STAT_LIVE_BIT = 8;

   typedef logic [IDX_W-1:0] src_idx_t;

   // Register word index = bus_addr[7:2]
   typedef enum logic [5:0] {
      REG_SEL   = 6'd0,
      REG_MODE  = 6'd1,
      REG_VEC   = 6'd2,
      REG_ACK   = 6'd3,
      REG_STAT  = 6'd4,
      REG_SPUR  = 6'd5,
      REG_EOI   = 6'd6,
      REG_MASK  = 6'd7,
      REG_EN    = 6'd8,
      REG_DIS   = 6'd9,
      REG_CLR   = 6'd10,
      REG_SET   = 6'd11,
      REG_PEND0 = 6'd12,
      REG_PEND1 = 6'd13,
      REG_PEND2 = 6'd14,
      REG_PEND3 = 6'd15
   } reg_word_e;

endpackage

// File: rtl/nest_intc_src_bank.sv
module nest_intc_src_bank
   import nest_intc_pkg::*;
#(
   parameter int NUM_SRC = 128,
   parameter int PRIO_W  = 3,
   parameter int VEC_W   = 32
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_SRC-1:0]                src_in,
   input  src_idx_t                          sel_idx,
   input  src_idx_t                          win_idx,
   input  logic                              wr_mode,
   input  logic                              wr_vec,
   input  logic                              wr_en,
   input  logic                              wr_dis,
   input  logic                              wr_clr,
   input  logic                              wr_set,
   input  logic [31:0]                       wdata,
   input  logic                              ack,
   output logic [NUM_SRC-1:0]                pend,
   output logic [NUM_SRC-1:0]                req,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]    prio_all,
   output logic [31:0]                       sel_mode,
   output logic [VEC_W-1:0]                  sel_vec,
   output logic                              sel_en,
   output logic [VEC_W-1:0]                  win_vec
);

   logic [NUM_SRC-1:0][VEC_W-1:0] vec_all;
   logic [NUM_SRC-1:0]            edge_all;
   logic [NUM_SRC-1:0]            pol_all;
   logic [NUM_SRC-1:0]            en_all;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic [PRIO_W-1:0] prio_q;
      logic [VEC_W-1:0]  vec_q;
      logic              edge_q, pol_q, en_q, pend_q, src_q;
      logic              hit, act_now, act_old, rise, set_i, clr_i;

      assign hit     = (sel_idx == IDX_W'(i));
      assign act_now = src_in[i] ^ pol_q;
      assign act_old = src_q ^ pol_q;
      assign rise    = act_now & ~act_old;
      assign set_i   = (wr_set & hit) | (edge_q & rise);
      assign clr_i   = (wr_clr & hit) | (ack & edge_q & (win_idx == IDX_W'(i)));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q <= '0;
            vec_q  <= '0;
            edge_q <= 1'b0;
            pol_q  <= 1'b0;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            src_q  <= 1'b0;
         end else begin
            src_q  <= src_in[i];
            pend_q <= (pend_q & ~clr_i) | set_i;
            if (wr_mode && hit) begin
               prio_q <= wdata[PRIO_W-1:0];
               edge_q <= wdata[MODE_EDGE_BIT];
               pol_q  <= wdata[MODE_POL_BIT];
            end
            if (wr_vec && hit) vec_q <= wdata[VEC_W-1:0];
            if (wr_en  && hit) en_q  <= 1'b1;
            if (wr_dis && hit) en_q  <= 1'b0;
         end
      end

      // Level sources stay pending while active; the latch holds software sets.
      assign pend[i]     = edge_q ? pend_q : (act_now | pend_q);
      assign req[i]      = pend[i] & en_q;
      assign prio_all[i] = prio_q;
      assign vec_all[i]  = vec_q;
      assign edge_all[i] = edge_q;
      assign pol_all[i]  = pol_q;
      assign en_all[i]   = en_q;

      AST_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_set && hit) |=> pend_q)
         else $error("set command did not latch pending"); // R6
      AST_DIS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_dis && hit && !wr_en) |=> !en_q)
         else $error("disable command left source enabled"); // R3
      AST_EDGE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_q && rise && !wr_mode) |=> pend_q)
         else $error("active edge not latched"); // R4
   end

   // Read-side muxes for the selected source and the arbitration winner.
   always_comb begin
      sel_mode = '0;
      sel_vec  = '0;
      sel_en   = 1'b0;
      win_vec  = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel_idx == IDX_W'(i)) begin
            sel_mode[PRIO_W-1:0]    = prio_all[i];
            sel_mode[MODE_EDGE_BIT] = edge_all[i];
            sel_mode[MODE_POL_BIT]  = pol_all[i];
            sel_vec                 = vec_all[i];
            sel_en                  = en_all[i];
         end
         if (win_idx == IDX_W'(i)) win_vec = vec_all[i];
      end
   end

endmodule

// File: rtl/nest_intc_arbiter.sv
module nest_intc_arbiter
   import nest_intc_pkg::*;
#(
   parameter int NUM_SRC = 128,
   parameter int PRIO_W  = 3
) (
   input  logic [NUM_SRC-1:0]             req,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all,
   output logic                           win_valid,
   output src_idx_t                       win_idx,
   output logic [PRIO_W-1:0]              win_prio
);

   // Scan from the top index down; ">=" lets a lower index take an equal priority.
   always_comb begin
      win_valid = 1'b0;
      win_idx   = '0;
      win_prio  = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (req[i] && (!win_valid || prio_all[i] >= win_prio)) begin
            win_valid = 1'b1;
            win_idx   = IDX_W'(i);
            win_prio  = prio_all[i];
         end
      end
   end

endmodule

// File: rtl/nest_intc_stack.sv
module nest_intc_stack
   import nest_intc_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int PRIO_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [PRIO_W-1:0] push_prio,
   input  logic              push_live,
   input  src_idx_t          push_idx,
   input  logic              pop,
   output logic              empty,
   output logic              full,
   output logic [PRIO_W-1:0] top_prio,
   output logic              top_live,
   output src_idx_t          top_idx
);

   localparam int CW = $clog2(DEPTH + 1);

   logic [CW-1:0]     cnt_q;
   logic [PRIO_W-1:0] prio_m [DEPTH];
   logic              live_m [DEPTH];
   src_idx_t          idx_m  [DEPTH];

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int k = 0; k < DEPTH; k++) begin
            prio_m[k] <= '0;
            live_m[k] <= 1'b0;
            idx_m[k]  <= '0;
         end
      end else if (push && !full) begin
         for (int k = 0; k < DEPTH; k++) begin
            if (cnt_q == CW'(k)) begin
               prio_m[k] <= push_prio;
               live_m[k] <= push_live;
               idx_m[k]  <= push_idx;
            end
         end
         cnt_q <= cnt_q + CW'(1);
      end else if (pop && !empty) begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   always_comb begin
      top_prio = '0;
      top_live = 1'b0;
      top_idx  = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (cnt_q == CW'(k + 1)) begin
            top_prio = prio_m[k];
            top_live = live_m[k];
            top_idx  = idx_m[k];
         end
      end
   end

   AST_POP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !empty) |=> (cnt_q == $past(cnt_q) - CW'(1)))
      else $error("pop did not drop a level"); // R11
   AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && empty) |=> empty)
      else $error("pop on empty stack changed depth"); // R11
   AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full) |=> (top_prio == $past(push_prio)))
      else $error("pushed priority not on top"); // R9

endmodule

// File: rtl/nest_intc.sv
module nest_intc
   import nest_intc_pkg::*;
#(
   parameter int NUM_SRC    = 128,
   parameter int PRIO_W     = 3,
   parameter int NEST_DEPTH = 8,
   parameter int VEC_W      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [7:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic               irq_out
);

   initial begin : p_param_check
      assert (NUM_SRC >= 1 && NUM_SRC <= MAX_SRC)
         else $fatal(1, "NUM_SRC out of range");
      assert (PRIO_W >= 1 && PRIO_W <= MODE_EDGE_BIT)
         else $fatal(1, "PRIO_W collides with mode flags");
      assert (NEST_DEPTH >= 1)
         else $fatal(1, "NEST_DEPTH must be positive");
      assert (VEC_W >= 1 && VEC_W <= 32)
         else $fatal(1, "VEC_W exceeds bus width");
   end

   reg_word_e word;
   logic      rd, wr;
   logic      unused_addr_lsb;

   assign word            = reg_word_e'(bus_addr[7:2]);
   assign rd              = bus_sel & ~bus_we;
   assign wr              = bus_sel & bus_we;
   assign unused_addr_lsb = ^bus_addr[1:0];

   src_idx_t   sel_q;
   logic [VEC_W-1:0] spur_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         spur_q <= '0;
      end else if (wr) begin
         if (word == REG_SEL)  sel_q  <= bus_wdata[IDX_W-1:0];
         if (word == REG_SPUR) spur_q <= bus_wdata[VEC_W-1:0];
      end
   end

   logic [NUM_SRC-1:0]             pend, req;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_all;
   logic [31:0]                    sel_mode;
   logic [VEC_W-1:0]               sel_vec, win_vec;
   logic                           sel_en;
   logic                           win_valid;
   src_idx_t                       win_idx;
   logic [PRIO_W-1:0]              win_prio;
   logic                           stk_empty, stk_full, top_live;
   logic [PRIO_W-1:0]              top_prio;
   src_idx_t                       top_idx;
   logic                           ack_rd, ack, eoi;
   logic [PRIO_W-1:0]              push_prio;

   assign ack_rd    = rd && (word == REG_ACK);
   assign ack       = ack_rd && irq_out;
   assign eoi       = wr && (word == REG_EOI);
   assign push_prio = irq_out ? win_prio : top_prio;   // top_prio is 0 when empty

   nest_intc_src_bank #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .VEC_W   (VEC_W)
   ) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_in   (src_in),
      .sel_idx  (sel_q),
      .win_idx  (win_idx),
      .wr_mode  (wr && word == REG_MODE),
      .wr_vec   (wr && word == REG_VEC),
      .wr_en    (wr && word == REG_EN  && bus_wdata[0]),
      .wr_dis   (wr && word == REG_DIS && bus_wdata[0]),
      .wr_clr   (wr && word == REG_CLR && bus_wdata[0]),
      .wr_set   (wr && word == REG_SET && bus_wdata[0]),
      .wdata    (bus_wdata),
      .ack      (ack),
      .pend     (pend),
      .req      (req),
      .prio_all (prio_all),
      .sel_mode (sel_mode),
      .sel_vec  (sel_vec),
      .sel_en   (sel_en),
      .win_vec  (win_vec)
   );

   nest_intc_arbiter #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W)
   ) arb_i (
      .req       (req),
      .prio_all  (prio_all),
      .win_valid (win_valid),
      .win_idx   (win_idx),
      .win_prio  (win_prio)
   );

   nest_intc_stack #(
      .DEPTH  (NEST_DEPTH),
      .PRIO_W (PRIO_W)
   ) stk_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (ack_rd),
      .push_prio (push_prio),
      .push_live (irq_out),
      .push_idx  (win_idx),
      .pop       (eoi),
      .empty     (stk_empty),
      .full      (stk_full),
      .top_prio  (top_prio),
      .top_live  (top_live),
      .top_idx   (top_idx)
   );

   assign irq_out = win_valid && !stk_full && (stk_empty || win_prio > top_prio);

   // Pending words always span the full source field; pad when fewer sources exist.
   logic [MAX_SRC-1:0] pend_ext;
   if (NUM_SRC == MAX_SRC) begin : g_pend_full
      assign pend_ext = pend;
   end else begin : g_pend_pad
      assign pend_ext = {{(MAX_SRC - NUM_SRC){1'b0}}, pend};
   end

   always_comb begin
      bus_rdata = '0;
      case (word)
         REG_SEL:   bus_rdata = 32'(sel_q);
         REG_MODE:  bus_rdata = sel_mode;
         REG_VEC:   bus_rdata = 32'(sel_vec);
         REG_ACK:   bus_rdata = irq_out ? 32'(win_vec) : 32'(spur_q);
         REG_STAT:  bus_rdata = top_live ? (32'(1) << STAT_LIVE_BIT) | 32'(top_idx) : '0;
         REG_SPUR:  bus_rdata = 32'(spur_q);
         REG_MASK:  bus_rdata = 32'(sel_en);
         REG_PEND0: bus_rdata = pend_ext[31:0];
         REG_PEND1: bus_rdata = pend_ext[63:32];
         REG_PEND2: bus_rdata = pend_ext[95:64];
         REG_PEND3: bus_rdata = pend_ext[127:96];
         default:   bus_rdata = '0;
      endcase
   end

   AST_IRQ_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (req != '0))
      else $error("request raised with nothing pending and enabled"); // R7
   AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (!stk_empty && top_live))
      else $error("acknowledge did not push a live level"); // R9
   AST_SPUR_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !irq_out && !stk_full) |=> !top_live)
      else $error("spurious acknowledge pushed a live level"); // R10
   AST_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      stk_full |-> !irq_out)
      else $error("request raised with full stack"); // R8

endmodule

// File: tb/nest_intc_tb.sv
module nest_intc_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC       = 128;

   localparam logic [7:0] A_SEL   = 8'h00;
   localparam logic [7:0] A_MODE  = 8'h04;
   localparam logic [7:0] A_VEC   = 8'h08;
   localparam logic [7:0] A_ACK   = 8'h0C;
   localparam logic [7:0] A_STAT  = 8'h10;
   localparam logic [7:0] A_SPUR  = 8'h14;
   localparam logic [7:0] A_EOI   = 8'h18;
   localparam logic [7:0] A_MASK  = 8'h1C;
   localparam logic [7:0] A_EN    = 8'h20;
   localparam logic [7:0] A_DIS   = 8'h24;
   localparam logic [7:0] A_CLR   = 8'h28;
   localparam logic [7:0] A_SET   = 8'h2C;
   localparam logic [7:0] A_PEND0 = 8'h30;
   localparam logic [7:0] A_PEND3 = 8'h3C;

   // Entry: {req[7:0], kind[1:0] (0 write, 1 read-check), addr[7:0], wdata[31:0], expect[31:0]}
   localparam int NT = 35;
   localparam logic [81:0] TBL [NT] = '{
      {8'd12, 2'd1, A_SEL,   32'h0,        32'h0},        // R12 select resets to 0
      {8'd12, 2'd1, A_SPUR,  32'h0,        32'h0},        // R12 spurious resets to 0
      {8'd12, 2'd1, A_STAT,  32'h0,        32'h0},        // R12 status idle
      {8'd1,  2'd0, A_SEL,   32'h5,        32'h0},        // R1
      {8'd1,  2'd1, A_SEL,   32'h0,        32'h5},        // R1 readback
      {8'd12, 2'd1, A_MODE,  32'h0,        32'h0},        // R12 mode reset
      {8'd2,  2'd0, A_MODE,  32'hFFFFFF33, 32'h0},        // R2 prio 3, edge, falling
      {8'd2,  2'd1, A_MODE,  32'h0,        32'h33},       // R2 unused bits read 0
      {8'd12, 2'd1, A_MASK,  32'h0,        32'h0},        // R12 disabled
      {8'd3,  2'd0, A_EN,    32'h1,        32'h0},        // R3
      {8'd3,  2'd1, A_MASK,  32'h0,        32'h1},        // R3 enabled
      {8'd1,  2'd0, A_VEC,   32'hCAFE0005, 32'h0},        // R1
      {8'd1,  2'd1, A_VEC,   32'h0,        32'hCAFE0005}, // R1
      {8'd1,  2'd0, A_SEL,   32'h6,        32'h0},        // R1 other source
      {8'd1,  2'd1, A_MASK,  32'h0,        32'h0},        // R1 untouched
      {8'd1,  2'd1, A_VEC,   32'h0,        32'h0},        // R1 untouched
      {8'd6,  2'd0, A_SET,   32'h1,        32'h0},        // R6
      {8'd13, 2'd1, A_PEND0, 32'h0,        32'h40},       // R13 bit 6
      {8'd6,  2'd0, A_CLR,   32'h1,        32'h0},        // R6
      {8'd6,  2'd1, A_PEND0, 32'h0,        32'h0},        // R6 cleared
      {8'd1,  2'd0, A_SEL,   32'd100,      32'h0},        // R1
      {8'd6,  2'd0, A_SET,   32'h1,        32'h0},        // R6
      {8'd13, 2'd1, A_PEND3, 32'h0,        32'h10},       // R13 source 100 -> bit 4
      {8'd13, 2'd1, A_PEND0, 32'h0,        32'h0},        // R13
      {8'd6,  2'd0, A_CLR,   32'h1,        32'h0},        // R6
      {8'd13, 2'd1, A_PEND3, 32'h0,        32'h0},        // R13
      {8'd1,  2'd0, A_SEL,   32'h5,        32'h0},        // R1
      {8'd3,  2'd0, A_DIS,   32'h1,        32'h0},        // R3
      {8'd3,  2'd1, A_MASK,  32'h0,        32'h0},        // R3 disabled
      {8'd3,  2'd0, A_EN,    32'h2,        32'h0},        // R3 bit 0 clear: ignored
      {8'd3,  2'd1, A_MASK,  32'h0,        32'h0},        // R3
      {8'd10, 2'd0, A_SPUR,  32'h5A5A,     32'h0},        // R10
      {8'd10, 2'd1, A_SPUR,  32'h0,        32'h5A5A},     // R10
      {8'd1,  2'd0, A_SEL,   32'h85,       32'h0},        // R1 high bits dropped
      {8'd1,  2'd1, A_SEL,   32'h0,        32'h5}         // R1
   };

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_sel, bus_we;
   logic [7:0]        bus_addr;
   logic [31:0]       bus_wdata, bus_rdata;
   logic [NSRC-1:0]   src_in;
   logic              irq_out;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   nest_intc #(.NUM_SRC(NSRC)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .src_in    (src_in),
      .irq_out   (irq_out)
   );

   task automatic chk(input int r, input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s actual %h expected %h", r, what, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input int r, input logic [7:0] a, input logic [31:0] exp, input string what);
      logic [31:0] d;
      bus_rd(a, d);
      chk(r, d, exp, what);
   endtask

   task automatic irq_chk(input int r, input logic exp, input string what);
      @(negedge clk);
      #1 chk(r, {31'b0, irq_out}, {31'b0, exp}, what);
   endtask

   task automatic setup_src(input int n, input logic [31:0] mode, input logic [31:0] vec);
      bus_wr(A_SEL, 32'(n));
      bus_wr(A_MODE, mode);
      bus_wr(A_VEC, vec);
      bus_wr(A_EN, 32'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog (all requirements) actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; src_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      irq_chk(12, 1'b0, "irq after reset");                     // R12

      for (int k = 0; k < NT; k++) begin
         logic [81:0] e;
         e = TBL[k];
         if (e[73:72] == 2'd0) bus_wr(e[71:64], e[63:32]);
         else rd_chk(int'(e[81:74]), e[71:64], e[31:0], $sformatf("table[%0d]", k));
      end

      // R10 spurious acknowledge with empty stack
      rd_chk(10, A_ACK, 32'h5A5A, "spurious vector");
      rd_chk(10, A_STAT, 32'h0, "status on spurious");
      bus_wr(A_EOI, 32'h0);

      // R5 level-high source 10, priority 2
      setup_src(10, 32'h02, 32'h100A);
      irq_chk(5, 1'b0, "level idle");
      @(negedge clk); src_in[10] = 1'b1;
      irq_chk(5, 1'b1, "level active");
      rd_chk(13, A_PEND0, 32'h400, "level pending bit");
      @(negedge clk); src_in[10] = 1'b0;
      irq_chk(5, 1'b0, "level released");
      rd_chk(5, A_PEND0, 32'h0, "level pending gone");

      // R4 rising edge source 20, priority 1
      setup_src(20, 32'h11, 32'h2014);
      @(negedge clk); src_in[20] = 1'b1;
      @(negedge clk); src_in[20] = 1'b0;
      irq_chk(4, 1'b1, "rising edge latched");
      rd_chk(4, A_PEND0, 32'h100000, "edge stays pending");
      rd_chk(9, A_ACK, 32'h2014, "ack vector src20");
      rd_chk(9, A_STAT, 32'h114, "status src20");
      irq_chk(9, 1'b0, "irq after ack");
      rd_chk(9, A_PEND0, 32'h0, "edge pending cleared by ack");
      bus_wr(A_EOI, 32'h0);
      rd_chk(11, A_STAT, 32'h0, "status after eoi");

      // R4 falling edge on source 5 (mode 0x33 from table)
      bus_wr(A_SEL, 32'h5);
      bus_wr(A_EN, 32'h1);
      @(negedge clk); src_in[5] = 1'b1;
      rd_chk(4, A_PEND0, 32'h0, "rising ignored when falling selected");
      @(negedge clk); src_in[5] = 1'b0;
      rd_chk(4, A_PEND0, 32'h20, "falling edge latched");
      irq_chk(4, 1'b1, "falling edge irq");
      rd_chk(9, A_ACK, 32'hCAFE0005, "ack vector src5");
      bus_wr(A_EOI, 32'h0);
      bus_wr(A_DIS, 32'h1);

      // R3 disabled source pending but silent
      bus_wr(A_SET, 32'h1);
      irq_chk(3, 1'b0, "disabled source silent");
      rd_chk(3, A_PEND0, 32'h20, "disabled source still pending");
      bus_wr(A_CLR, 32'h1);

      // R7 / R8 arbitration and nesting
      setup_src(30, 32'h12, 32'h301E);
      bus_wr(A_SET, 32'h1);
      bus_wr(A_SEL, 32'd20);
      bus_wr(A_SET, 32'h1);
      @(negedge clk); src_in[10] = 1'b1;
      rd_chk(7, A_ACK, 32'h100A, "tie goes to lowest index");
      rd_chk(9, A_PEND0, 32'h40100400, "level kept, edges kept");
      irq_chk(8, 1'b0, "equal priority does not nest");
      setup_src(40, 32'h15, 32'h4028);
      bus_wr(A_SET, 32'h1);
      irq_chk(8, 1'b1, "higher priority nests");
      rd_chk(8, A_ACK, 32'h4028, "nested vector");
      rd_chk(9, A_STAT, 32'h128, "nested status");
      bus_wr(A_EOI, 32'h0);
      rd_chk(11, A_STAT, 32'h10A, "status reverts");
      irq_chk(8, 1'b0, "still blocked at level 2");
      bus_wr(A_EOI, 32'h0);
      @(negedge clk); src_in[10] = 1'b0;
      irq_chk(8, 1'b1, "stack empty, pending served");
      rd_chk(7, A_ACK, 32'h301E, "priority 2 beats priority 1");
      rd_chk(9, A_STAT, 32'h11E, "status src30");
      bus_wr(A_EOI, 32'h0);
      rd_chk(7, A_ACK, 32'h2014, "last remaining source");
      bus_wr(A_EOI, 32'h0);
      irq_chk(7, 1'b0, "nothing left");

      // R11 / R8 fill the stack with spurious levels, then unwind
      for (int k = 0; k < 9; k++) rd_chk(10, A_ACK, 32'h5A5A, "spurious fill");
      bus_wr(A_SEL, 32'd20);
      bus_wr(A_SET, 32'h1);
      irq_chk(8, 1'b0, "full stack blocks request");
      rd_chk(10, A_STAT, 32'h0, "status with spurious top");
      for (int k = 0; k < 8; k++) bus_wr(A_EOI, 32'h0);
      irq_chk(11, 1'b1, "eight pops unwind");
      for (int k = 0; k < 3; k++) bus_wr(A_EOI, 32'h0);
      irq_chk(11, 1'b1, "extra pops harmless");
      rd_chk(9, A_ACK, 32'h2014, "vector after unwind");
      bus_wr(A_EOI, 32'h0);
      irq_chk(11, 1'b0, "idle at end");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule